// File: doc/BRIEF.md
# Multi-Port Hardware Semaphore Bank

This block holds a set of hardware semaphores that several processor cores use to guard shared resources. Every core reaches the bank through its own single-cycle register port: a byte address, a write strobe with write data, a read strobe, and a fixed master identifier that names the core behind the port. Each semaphore occupies one aligned 32-bit word.

A core claims a semaphore by writing a word with the lock flag (bit 31) set and its own identifier in the 4-bit owner field at bits 11:8. It then reads the same word back. The claim has succeeded only when the word reads as exactly the lock flag plus that identifier. A write never stalls and never reports an error. A core frees a semaphore it owns by writing its identifier with the lock flag clear. When ports write to the same semaphore in the same cycle, the lowest-numbered port wins, so two cores can never both hold one semaphore.

Top module: `hsem_bank`

## Requirements
- R1: After reset every semaphore is free and reads as 0x00000000 on every port.
- R2: Semaphore i is reached at byte address 4*i. Read data appears on the port's read data output one cycle after the read strobe. A read of an address whose two low bits are not zero returns zero, and a write to such an address has no effect.
- R3: A write with bit 31 set and bits 11:8 equal to the port's master identifier claims a free semaphore and records that identifier as its owner.
- R4: A held semaphore reads as 0x80000000 plus (owner << 8). A free one reads as 0. Every bit outside 31 and 11:8 always reads zero.
- R5: A claim write to a semaphore that is already held, whether by another core or by the same core, leaves its state and owner unchanged.
- R6: A write with bit 31 clear and bits 11:8 equal to the port's master identifier frees the semaphore only when that identifier is the recorded owner. Otherwise the write is ignored.
- R7: A write is ignored when its bits 11:8 differ from the port's master identifier, or when any bit other than 31 and 11:8 is set.
- R8: When several ports write to the same semaphore in one cycle, only the write of the lowest-numbered port is evaluated. The others are dropped, even when the winning write is itself ignored.
- R9: Addresses beyond the last semaphore word read zero, and writes to them change no semaphore.
- R10: Writes from different ports to different semaphores in the same cycle each take effect.
- R11: A read issued in the same cycle as a write to the same semaphore returns the state from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; its release is synchronized inside the block |
| bus_addr | input | NPORT x ADDR_W | Byte address for each port |
| bus_we | input | NPORT | Write strobe for each port |
| bus_wdata | input | NPORT x 32 | Write data for each port |
| bus_re | input | NPORT | Read strobe for each port |
| bus_mid | input | NPORT x ID_W | Master identifier of the core behind each port |
| bus_rdata | output | NPORT x 32 | Registered read data for each port |

## Verification
Three kinds of operation can fall in the same cycle: claims from two ports on one semaphore, a release from one port together with a claim from another on the same semaphore, and a read on one port together with a write on another to the same word. The bench provokes each case by driving both ports on the same clock edge. It judges the outcome through a later readback, which must show the lower port as owner, or the semaphore free after a release that wins. In the read-with-write case the bench checks the data returned in that same cycle, which must show the state from before the write.

// File: rtl/hsem_pkg.sv
package hsem_pkg;

  localparam int DATA_W   = 32;
  localparam int LOCK_POS = 31;

  typedef enum logic [1:0] {
    WR_NONE = 2'd0,
    WR_LOCK = 2'd1,
    WR_REL  = 2'd2
  } wr_kind_e;

  // Bits that may legally be non-zero in a semaphore word
  function automatic logic [DATA_W-1:0] live_mask(input int id_w, input int id_lsb);
    logic [DATA_W-1:0] m;
    m = '0;
    m[LOCK_POS] = 1'b1;
    for (int b = 0; b < id_w; b++) m[id_lsb + b] = 1'b1;
    return m;
  endfunction

endpackage

// File: rtl/hsem_port_decode.sv
module hsem_port_decode
  import hsem_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int NUM_SEM = 32,
  parameter int ID_W    = 4,
  parameter int ID_LSB  = 8,
  localparam int IDX_W  = $clog2(NUM_SEM)
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ID_W-1:0]   mid,
  output logic              in_win,
  output logic [IDX_W-1:0]  idx,
  output wr_kind_e          kind
);

  localparam logic [DATA_W-1:0] LIVE = live_mask(ID_W, ID_LSB);

  logic aligned;
  logic upper_zero;
  logic id_match;
  logic clean;

  always_comb begin
    aligned    = (addr[1:0] == 2'b00);
    upper_zero = (addr[ADDR_W-1:IDX_W+2] == '0);
    idx        = addr[IDX_W+1:2];
    in_win     = aligned && upper_zero && (int'(idx) < NUM_SEM);
    id_match   = (wdata[ID_LSB +: ID_W] == mid);
    clean      = ((wdata & ~LIVE) == '0);
    kind       = WR_NONE;
    if (we && in_win && id_match && clean) begin
      kind = wdata[LOCK_POS] ? WR_LOCK : WR_REL;
    end
  end

endmodule

// File: rtl/hsem_cell.sv
module hsem_cell
  import hsem_pkg::*;
#(
  parameter int NPORT   = 2,
  parameter int ID_W    = 4,
  parameter int IDX_W   = 5,
  parameter int SEM_IDX = 0
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  wr_kind_e [NPORT-1:0]        port_kind,
  input  logic [NPORT-1:0][IDX_W-1:0] port_idx,
  input  logic [NPORT-1:0][ID_W-1:0]  port_mid,
  output logic                        held,
  output logic [ID_W-1:0]             owner
);

  localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(SEM_IDX);

  wr_kind_e        sel_kind;
  logic [ID_W-1:0] sel_mid;
  logic            held_q, held_d;
  logic [ID_W-1:0] owner_q, owner_d;
  logic            upd;

  // Fixed priority: lowest port index addressing this semaphore wins
  always_comb begin
    sel_kind = WR_NONE;
    sel_mid  = '0;
    for (int p = NPORT - 1; p >= 0; p--) begin
      if (port_kind[p] != WR_NONE && port_idx[p] == MY_IDX) begin
        sel_kind = port_kind[p];
        sel_mid  = port_mid[p];
      end
    end
  end

  always_comb begin
    held_d  = held_q;
    owner_d = owner_q;
    upd     = 1'b0;
    case (sel_kind)
      WR_LOCK: begin
        if (!held_q) begin
          held_d  = 1'b1;
          owner_d = sel_mid;
          upd     = 1'b1;
        end
      end
      WR_REL: begin
        if (held_q && owner_q == sel_mid) begin
          held_d = 1'b0;
          upd    = 1'b1;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q  <= 1'b0;
      owner_q <= '0;
    end else if (upd) begin
      held_q  <= held_d;
      owner_q <= owner_d;
    end
  end

  assign held  = held_q;
  assign owner = owner_q;

  // R3
  take_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!held_q && sel_kind == WR_LOCK) |=> (held_q && owner_q == $past(sel_mid)));

  // R5
  held_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (held_q && sel_kind != WR_REL) |=> (held_q && owner_q == $past(owner_q)));

  // R6
  foreign_rel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (held_q && sel_kind == WR_REL && sel_mid != owner_q) |=> held_q);

endmodule

// File: rtl/hsem_read_port.sv
module hsem_read_port
  import hsem_pkg::*;
#(
  parameter int NUM_SEM = 32,
  parameter int ID_W    = 4,
  parameter int ID_LSB  = 8,
  parameter int IDX_W   = 5
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          rd_en,
  input  logic                          in_win,
  input  logic [IDX_W-1:0]              idx,
  input  logic [NUM_SEM-1:0]            held,
  input  logic [NUM_SEM-1:0][ID_W-1:0]  owner,
  output logic [DATA_W-1:0]             rdata
);

  localparam logic [DATA_W-1:0] LIVE = live_mask(ID_W, ID_LSB);

  logic [DATA_W-1:0] word_d;
  logic [DATA_W-1:0] rdata_q;

  always_comb begin
    word_d = '0;
    if (in_win && held[idx]) begin
      word_d[LOCK_POS]          = 1'b1;
      word_d[ID_LSB +: ID_W]    = owner[idx];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (rd_en) begin
      rdata_q <= word_d;
    end
  end

  assign rdata = rdata_q;

  // R9
  oob_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !in_win) |=> (rdata_q == '0));

  // R4
  dead_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((rdata_q & ~LIVE) == '0));

  // R4
  free_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rdata_q[LOCK_POS]) |-> (rdata_q == '0));

endmodule

// File: rtl/hsem_bank.sv
module hsem_bank
  import hsem_pkg::*;
#(
  parameter int NPORT   = 2,
  parameter int NUM_SEM = 32,
  parameter int ADDR_W  = 8,
  parameter int ID_W    = 4,
  parameter int ID_LSB  = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NPORT-1:0][ADDR_W-1:0]  bus_addr,
  input  logic [NPORT-1:0]              bus_we,
  input  logic [NPORT-1:0][31:0]        bus_wdata,
  input  logic [NPORT-1:0]              bus_re,
  input  logic [NPORT-1:0][ID_W-1:0]    bus_mid,
  output logic [NPORT-1:0][31:0]        bus_rdata
);

  localparam int IDX_W = $clog2(NUM_SEM);

  // Reset: asserted asynchronously, released on a clock edge
  logic rst_q1, rst_q2;
  logic rst_n_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_q1 <= 1'b0;
      rst_q2 <= 1'b0;
    end else begin
      rst_q1 <= 1'b1;
      rst_q2 <= rst_q1;
    end
  end

  assign rst_n_int = rst_q2;

  wr_kind_e [NPORT-1:0]           port_kind;
  logic [NPORT-1:0][IDX_W-1:0]    port_idx;
  logic [NPORT-1:0]               port_win;
  logic [NUM_SEM-1:0]             sem_held;
  logic [NUM_SEM-1:0][ID_W-1:0]   sem_owner;

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    hsem_port_decode #(
      .ADDR_W (ADDR_W),
      .NUM_SEM(NUM_SEM),
      .ID_W   (ID_W),
      .ID_LSB (ID_LSB)
    ) u_dec (
      .addr  (bus_addr[p]),
      .we    (bus_we[p]),
      .wdata (bus_wdata[p]),
      .mid   (bus_mid[p]),
      .in_win(port_win[p]),
      .idx   (port_idx[p]),
      .kind  (port_kind[p])
    );

    hsem_read_port #(
      .NUM_SEM(NUM_SEM),
      .ID_W   (ID_W),
      .ID_LSB (ID_LSB),
      .IDX_W  (IDX_W)
    ) u_rd (
      .clk   (clk),
      .rst_n (rst_n_int),
      .rd_en (bus_re[p]),
      .in_win(port_win[p]),
      .idx   (port_idx[p]),
      .held  (sem_held),
      .owner (sem_owner),
      .rdata (bus_rdata[p])
    );
  end

  for (genvar s = 0; s < NUM_SEM; s++) begin : g_sem
    hsem_cell #(
      .NPORT  (NPORT),
      .ID_W   (ID_W),
      .IDX_W  (IDX_W),
      .SEM_IDX(s)
    ) u_cell (
      .clk      (clk),
      .rst_n    (rst_n_int),
      .port_kind(port_kind),
      .port_idx (port_idx),
      .port_mid (bus_mid),
      .held     (sem_held[s]),
      .owner    (sem_owner[s])
    );
  end

endmodule

// File: tb/hsem_bank_test.sv
module hsem_bank_test;

  localparam int CLK_PERIOD = 10;
  localparam int NPORT = 2;
  localparam int ADDR_W = 8;
  localparam int ID_W = 4;

  logic                          clk;
  logic                          rst_n;
  logic [NPORT-1:0][ADDR_W-1:0]  bus_addr;
  logic [NPORT-1:0]              bus_we;
  logic [NPORT-1:0][31:0]        bus_wdata;
  logic [NPORT-1:0]              bus_re;
  logic [NPORT-1:0][ID_W-1:0]    bus_mid;
  logic [NPORT-1:0][31:0]        bus_rdata;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  hsem_bank uut (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_addr (bus_addr),
    .bus_we   (bus_we),
    .bus_wdata(bus_wdata),
    .bus_re   (bus_re),
    .bus_mid  (bus_mid),
    .bus_rdata(bus_rdata)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  // Port 0 belongs to core 1, port 1 to core 3
  function automatic logic [31:0] claim_w(int id);
    return 32'h8000_0000 | (32'(id) << 8);
  endfunction

  function automatic logic [31:0] free_w(int id);
    return 32'(id) << 8;
  endfunction

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %08h expected %08h", tag, got, exp);
    end
  endtask

  task automatic do_write(int p, logic [ADDR_W-1:0] a, logic [31:0] d);
    @(negedge clk);
    bus_addr[p]  = a;
    bus_wdata[p] = d;
    bus_we[p]    = 1'b1;
    @(negedge clk);
    bus_we[p]    = 1'b0;
  endtask

  task automatic do_read(int p, logic [ADDR_W-1:0] a, output logic [31:0] v);
    @(negedge clk);
    bus_addr[p] = a;
    bus_re[p]   = 1'b1;
    @(negedge clk);
    bus_re[p]   = 1'b0;
    v = bus_rdata[p];
  endtask

  task automatic t_reset;
    logic [31:0] v;
    do_read(0, 8'd0, v);   check("R1 sem0 port0", v, 32'h0);
    do_read(1, 8'd20, v);  check("R1 sem5 port1", v, 32'h0);
    do_read(0, 8'd124, v); check("R1 sem31 port0", v, 32'h0);
  endtask

  task automatic t_claim;
    logic [31:0] v;
    do_write(0, 8'd12, claim_w(1));
    do_read(0, 8'd12, v); check("R3 claim sem3 by core1", v, claim_w(1));
    do_read(1, 8'd12, v); check("R4 readback format on port1", v, 32'h8000_0100);
    do_read(0, 8'd16, v); check("R10 sem4 untouched", v, 32'h0);
    do_read(0, 8'd14, v); check("R2 misaligned read is zero", v, 32'h0);
    do_write(1, 8'd124, claim_w(3));
    do_read(1, 8'd124, v); check("R3 claim sem31 by core3", v, 32'h8000_0300);
  endtask

  task automatic t_contend;
    logic [31:0] v;
    do_write(1, 8'd12, claim_w(3));
    do_read(1, 8'd12, v); check("R5 foreign claim ignored", v, claim_w(1));
    do_write(0, 8'd12, claim_w(1));
    do_read(0, 8'd12, v); check("R5 repeat claim by owner", v, claim_w(1));
    do_write(1, 8'd12, free_w(3));
    do_read(0, 8'd12, v); check("R6 foreign release ignored", v, claim_w(1));
    do_write(0, 8'd13, free_w(1));
    do_read(0, 8'd12, v); check("R2 misaligned release ignored", v, claim_w(1));
    do_write(0, 8'd12, free_w(1));
    do_read(0, 8'd12, v); check("R6 owner release frees", v, 32'h0);
    do_write(1, 8'd124, free_w(3));
    do_read(0, 8'd124, v); check("R6 core3 frees sem31", v, 32'h0);
  endtask

  task automatic t_bad_write;
    logic [31:0] v;
    do_write(0, 8'd28, claim_w(3));
    do_read(0, 8'd28, v); check("R7 wrong id field ignored", v, 32'h0);
    do_write(0, 8'd28, claim_w(1) | 32'h0000_0001);
    do_read(0, 8'd28, v); check("R7 stray data bit ignored", v, 32'h0);
  endtask

  task automatic t_collide;
    logic [31:0] v;
    @(negedge clk);
    bus_addr[0] = 8'd36; bus_wdata[0] = claim_w(1); bus_we[0] = 1'b1;
    bus_addr[1] = 8'd36; bus_wdata[1] = claim_w(3); bus_we[1] = 1'b1;
    @(negedge clk);
    bus_we = '0;
    do_read(1, 8'd36, v); check("R8 dual claim lower port wins", v, claim_w(1));
    @(negedge clk);
    bus_addr[0] = 8'd36; bus_wdata[0] = free_w(1);  bus_we[0] = 1'b1;
    bus_addr[1] = 8'd36; bus_wdata[1] = claim_w(3); bus_we[1] = 1'b1;
    @(negedge clk);
    bus_we = '0;
    do_read(1, 8'd36, v); check("R8 release wins, claim dropped", v, 32'h0);
    @(negedge clk);
    bus_addr[0] = 8'd40; bus_wdata[0] = claim_w(1); bus_we[0] = 1'b1;
    bus_addr[1] = 8'd44; bus_wdata[1] = claim_w(3); bus_we[1] = 1'b1;
    @(negedge clk);
    bus_we = '0;
    do_read(0, 8'd40, v); check("R10 sem10 claimed by core1", v, claim_w(1));
    do_read(0, 8'd44, v); check("R10 sem11 claimed by core3", v, claim_w(3));
  endtask

  task automatic t_out_of_window;
    logic [31:0] v;
    do_write(0, 8'h80, claim_w(1));
    do_read(0, 8'd0, v);   check("R9 write beyond window no alias", v, 32'h0);
    do_read(0, 8'h80, v);  check("R9 read beyond window", v, 32'h0);
    do_read(1, 8'hA8, v);  check("R9 read beyond window alias of sem10", v, 32'h0);
  endtask

  task automatic t_read_during_write;
    logic [31:0] v;
    @(negedge clk);
    bus_addr[1] = 8'd48; bus_re[1] = 1'b1;
    bus_addr[0] = 8'd48; bus_wdata[0] = claim_w(1); bus_we[0] = 1'b1;
    @(negedge clk);
    bus_re = '0;
    bus_we = '0;
    check("R11 read sees pre-write state", bus_rdata[1], 32'h0);
    do_read(1, 8'd48, v); check("R11 later read sees claim", v, claim_w(1));
  endtask

  initial begin
    bus_addr  = '0;
    bus_we    = '0;
    bus_wdata = '0;
    bus_re    = '0;
    bus_mid[0] = 4'd1;
    bus_mid[1] = 4'd3;
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_claim();
    t_contend();
    t_bad_write();
    t_collide();
    t_out_of_window();
    t_read_during_write();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule